// File: doc/BRIEF.md
# Adaptive Clock-Rate Step Controller

This block picks a rate divisor for a processing clock domain once the receiver's carrier tracking has locked. A quality count arrives once per full symbol period, flagged by a one-cycle end-of-period strobe. When lock is held and the strobe fires, the count is compared against two programmable limits. A count above the upper limit doubles the divisor. A count at or below the lower limit halves it. The divisor only ever takes the values 1, 2 and 4, so a 50 MHz processing rate can drop to a fraction of that in quiet operation.

Internally the divisor is kept as a power-of-two exponent. A clock-enable pulse is derived from it, so downstream logic does work on one cycle out of every divisor cycles. Losing lock sends the block straight back to full rate.

Top module: `rate_step_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `div_o` is 1 and `ce_o` is 1.
- R2: When `lock_i` is 1, `period_end_i` is 1 and `quality_i > thr_up_i` (unsigned), the divisor seen on the next cycle is twice the present one, unless it is already 4.
- R3: When `lock_i` is 1, `period_end_i` is 1, `quality_i > thr_up_i` is false and `quality_i <= thr_dn_i`, the divisor on the next cycle is half the present one, unless it is already 1. If both comparisons are true, doubling wins.
- R4: The divisor saturates: a doubling request at 4 leaves it at 4, and a halving request at 1 leaves it at 1.
- R5: When `lock_i` is 0, the divisor on the next cycle is 1, whatever the strobe and the quality count are.
- R6: With `lock_i` at 1, the divisor does not change on a cycle where `period_end_i` is 0, or where the count lies strictly above `thr_dn_i` and not above `thr_up_i`.
- R7: In the first cycle that shows a new divisor value, `ce_o` is 1. After that, while the divisor holds, `ce_o` is 1 on exactly one cycle in every `div_o` cycles and 0 on the others. With a divisor of 1 it is always 1.
- R8: `div_o` is always one-hot: its binary value is 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Carrier lock indication |
| period_end_i | input | 1 | One-cycle strobe marking the end of a full symbol period |
| quality_i | input | 8 | Quality count for the period just ended |
| thr_up_i | input | 8 | Upper limit; a count above it requests a slower rate |
| thr_dn_i | input | 8 | Lower limit; a count at or below it requests a faster rate |
| div_o | output | 3 | Current divisor, one-hot (1, 2 or 4) |
| ce_o | output | 1 | Clock-enable pulse, high once per divisor cycles |

## Verification
Directed runs climb the divisor to 4 and then press it against the ceiling. They come back down to 1 and press against the floor, which separates a correct step from wrap-around and from a clamp applied at the wrong edge. Other cases hold the count inside the band, withhold the strobe, or drop lock with the strobe low. These show that only the strobe moves the divisor, while lock loss acts on any cycle. Randomised traffic mixes lock drops, sparse strobes and limit pairs that sometimes cross. This exercises the doubling-over-halving priority and the enable phase restarting on every divisor change.

// File: rtl/rate_step_pkg.sv
package rate_step_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_FLOOR = 2'd3
    } step_cmd_e;

endpackage

// File: rtl/rate_step_decide.sv
module rate_step_decide
    import rate_step_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          lock_i,
    input  logic          period_end_i,
    input  logic [QW-1:0] quality_i,
    input  logic [QW-1:0] thr_up_i,
    input  logic [QW-1:0] thr_dn_i,
    output step_cmd_e     cmd_o
);

    logic above_up;
    logic at_or_below_dn;

    always_comb begin
        above_up       = quality_i > thr_up_i;
        at_or_below_dn = quality_i <= thr_dn_i;
        cmd_o          = STEP_HOLD;
        if (!lock_i) begin
            cmd_o = STEP_FLOOR;
        end else if (period_end_i) begin
            if (above_up) begin
                cmd_o = STEP_UP;
            end else if (at_or_below_dn) begin
                cmd_o = STEP_DOWN;
            end
        end
    end

endmodule

// File: rtl/rate_step_exp.sv
module rate_step_exp
    import rate_step_pkg::*;
#(
    parameter int MAX_EXP = 2,
    localparam int EW = (MAX_EXP < 2) ? 1 : $clog2(MAX_EXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_cmd_e     cmd_i,
    output logic [EW-1:0] exp_o,
    output logic          changed_o
);

    localparam logic [EW-1:0] EXP_TOP = EW'(MAX_EXP);

    typedef struct packed {
        logic [EW-1:0] exp_val;
    } exp_state_t;

    exp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            STEP_FLOOR: st_d.exp_val = '0;
            STEP_UP: begin
                if (st_q.exp_val < EXP_TOP) st_d.exp_val = st_q.exp_val + 1'b1;
            end
            STEP_DOWN: begin
                if (st_q.exp_val != '0) st_d.exp_val = st_q.exp_val - 1'b1;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exp_o     = st_q.exp_val;
    assign changed_o = st_d.exp_val != st_q.exp_val;

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_UP && exp_o < EXP_TOP) |=> exp_o == $past(exp_o) + 1'b1);
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_DOWN && exp_o != '0) |=> exp_o == $past(exp_o) - 1'b1);
    p_clamp_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_UP && exp_o == EXP_TOP) |=> exp_o == EXP_TOP);
    p_clamp_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_DOWN && exp_o == '0) |=> exp_o == '0);
    p_unlock_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_FLOOR) |=> exp_o == '0);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == STEP_HOLD) |=> $stable(exp_o));

endmodule

// File: rtl/rate_step_ce.sv
module rate_step_ce #(
    parameter int MAX_EXP = 2,
    localparam int EW = (MAX_EXP < 2) ? 1 : $clog2(MAX_EXP + 1),
    localparam int CW = (MAX_EXP < 1) ? 1 : MAX_EXP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] exp_i,
    input  logic          restart_i,
    output logic          ce_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ce_state_t;

    ce_state_t     st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = CW'((32'd1 << exp_i) - 32'd1);
        st_d     = st_q;
        if (restart_i || st_q.cnt == last_cnt) st_d.cnt = '0;
        else                                   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_o = st_q.cnt == '0;

    p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> ce_o);
    p_full_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_i == '0 && !restart_i) |=> ce_o);

endmodule

// File: rtl/rate_step_ctrl.sv
module rate_step_ctrl
    import rate_step_pkg::*;
#(
    parameter int QW      = 8,
    parameter int MAX_EXP = 2,
    localparam int EW = (MAX_EXP < 2) ? 1 : $clog2(MAX_EXP + 1),
    localparam int DW = MAX_EXP + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_i,
    input  logic          period_end_i,
    input  logic [QW-1:0] quality_i,
    input  logic [QW-1:0] thr_up_i,
    input  logic [QW-1:0] thr_dn_i,
    output logic [DW-1:0] div_o,
    output logic          ce_o
);

    step_cmd_e     cmd;
    logic [EW-1:0] exp_q;
    logic          exp_changed;

    rate_step_decide #(.QW(QW)) u_decide (
        .lock_i       (lock_i),
        .period_end_i (period_end_i),
        .quality_i    (quality_i),
        .thr_up_i     (thr_up_i),
        .thr_dn_i     (thr_dn_i),
        .cmd_o        (cmd)
    );

    rate_step_exp #(.MAX_EXP(MAX_EXP)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .exp_o     (exp_q),
        .changed_o (exp_changed)
    );

    rate_step_ce #(.MAX_EXP(MAX_EXP)) u_ce (
        .clk       (clk),
        .rst_n     (rst_n),
        .exp_i     (exp_q),
        .restart_i (exp_changed),
        .ce_o      (ce_o)
    );

    assign div_o = DW'(1) << exp_q;

    p_div_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(div_o));
    p_unlock_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> div_o == DW'(1));

endmodule

// File: tb/rate_step_ctrl_tb.sv
module rate_step_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lock_i;
    logic       period_end_i;
    logic [7:0] quality_i;
    logic [7:0] thr_up_i;
    logic [7:0] thr_dn_i;
    logic [2:0] div_o;
    logic       ce_o;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    int    m_exp = 0;
    int    m_cnt = 0;
    string div_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rate_step_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_i       (lock_i),
        .period_end_i (period_end_i),
        .quality_i    (quality_i),
        .thr_up_i     (thr_up_i),
        .thr_dn_i     (thr_dn_i),
        .div_o        (div_o),
        .ce_o         (ce_o)
    );

    function automatic int next_exp(int e, bit lk, bit pe, int q, int up, int dn);
        if (!lk) return 0;
        if (!pe) return e;
        if (q > up) return (e < 2) ? e + 1 : 2;
        if (q <= dn) return (e > 0) ? e - 1 : 0;
        return e;
    endfunction

    function automatic string cause(int e, bit lk, bit pe, int q, int up, int dn);
        if (!lk) return "R5";
        if (!pe) return "R6";
        if (q > up) return (e == 2) ? "R4" : "R2";
        if (q <= dn) return (e == 0) ? "R4" : "R3";
        return "R6";
    endfunction

    task automatic check(string tag, int act, int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    task automatic step(bit lk, bit pe, int q, int up, int dn);
        int ne;
        lock_i       = lk;
        period_end_i = pe;
        quality_i    = 8'(q);
        thr_up_i     = 8'(up);
        thr_dn_i     = 8'(dn);
        @(posedge clk);
        ne      = next_exp(m_exp, lk, pe, q, up, dn);
        div_tag = cause(m_exp, lk, pe, q, up, dn);
        if (ne != m_exp) m_cnt = 0;
        else if (m_cnt == (1 << m_exp) - 1) m_cnt = 0;
        else m_cnt = m_cnt + 1;
        m_exp = ne;
        @(negedge clk);
        check(div_tag, int'(div_o), 1 << m_exp);
        check("R7", int'(ce_o), (m_cnt == 0) ? 1 : 0);
        check("R8", $countones(div_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; lock_i = 1'b1; period_end_i = 1'b1;
        quality_i = 8'd255; thr_up_i = 8'd10; thr_dn_i = 8'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(div_o), 1);
        check("R1", int'(ce_o), 1);
        rst_n = 1'b1;
        m_exp = 0; m_cnt = 0;

        // R2: climb to 4
        step(1, 1, 200, 150, 50);
        step(1, 1, 200, 150, 50);
        // R4: ceiling
        step(1, 1, 255, 150, 50);
        // R7: ce every 4 cycles, R6: no strobe holds
        for (int i = 0; i < 9; i++) step(1, 0, 255, 150, 50);
        // R6: mid band with strobe holds
        step(1, 1, 100, 150, 50);
        step(1, 1, 150, 150, 50);
        // R3: halve to 2 then 1, boundary q == dn
        step(1, 1, 50, 150, 50);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 150, 50);
        step(1, 1, 10, 150, 50);
        // R4: floor
        step(1, 1, 0, 150, 50);
        // R3 priority: crossed limits, doubling wins
        step(1, 1, 100, 80, 120);
        step(1, 1, 100, 80, 120);
        // R5: lock loss without strobe
        step(0, 0, 100, 80, 120);
        step(0, 1, 255, 10, 5);
        step(1, 0, 255, 10, 5);

        for (int i = 0; i < 4000; i++) begin
            bit lk;
            bit pe;
            int up;
            int dn;
            lk = ($urandom_range(0, 19) != 0);
            pe = ($urandom_range(0, 4) == 0);
            up = $urandom_range(100, 200);
            dn = ($urandom_range(0, 9) == 0) ? $urandom_range(100, 255)
                                             : $urandom_range(0, 100);
            step(lk, pe, $urandom_range(0, 255), up, dn);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule